// File: doc/BRIEF.md
# SPI Transfer Byte Buffers with Word Access

This block holds the data for one serial peripheral port. It has a 16-byte transmit queue and a 16-byte receive queue, and it sits between a 32-bit register port and a serial shift engine. Software loads transmit data four bytes at a time and collects received data four bytes at a time. The shift engine takes and delivers single bytes.

The block also reports queue state and keeps a small set of sticky event flags. Two of those flags let an interrupt handler keep a long burst going: one says the transmit queue has run dry, and one says the receive queue has filled. Another flag marks the end of a whole transfer. Two more flags record access errors.

Register words, selected by `reg_addr_i`:

| Address | Access | Use |
|---------|--------|-----|
| 0 to 3 | write | Transmit word. All four addresses behave the same way. |
| 4 to 7 | read | Receive word. All four addresses behave the same way. |
| 8 | read | Status word. |
| 9 | read, write 1 to clear | Event flags. |
| 10 | read, write | Event mask. |

Every other address reads as zero.

Event flag bits, which the mask uses in the same positions:

| Bit | Flag |
|-----|------|
| 0 | Transmit queue became empty |
| 1 | Receive queue became full |
| 2 | Transfer done |
| 3 | Transmit error |
| 4 | Receive error |

Top module: `spi_fifo_regs`

## Requirements
- R1: After reset, both queues are empty. The status word reads 0x14, the event flags read 0, the mask reads 0 and `irq_o` is low.
- R2: A write to any of addresses 0 to 3 appends four bytes to the transmit queue. Bits 7:0 go first, then 15:8, then 23:16, then 31:24. Words leave in the order they were written. The engine sees the oldest byte on `tx_byte_o`, and `tx_valid_o` is high whenever the queue is not empty.
- R3: A transmit word write made while fewer than four entries are free is dropped whole and sets flag bit 3. The queue contents are unchanged.
- R4: A `tx_pop_i` made while the transmit queue is empty has no effect on the queue and sets flag bit 3.
- R5: A read of any of addresses 4 to 7 returns up to four of the oldest received bytes and removes them from the queue. The oldest byte is in bits 7:0. When fewer than four bytes are stored, the lanes without a byte read as zero.
- R6: An `rx_push_i` made while the receive queue is full is dropped and sets flag bit 4. A receive word read made while the receive queue is empty returns 0 and sets flag bit 4.
- R7: The status word at address 8 has these bits: bit 2 transmit empty, bit 3 transmit full, bit 4 receive empty, bit 5 receive full, bit 6 equal to `busy_i`. All other bits are zero. A queue is never reported full and empty at the same time.
- R8: Flag bit 0 is set when the transmit queue goes from non-empty to empty. Flag bit 1 is set when the receive queue goes from not full to full. Flag bit 2 is set by a `done_i` pulse. Each flag stays set until software clears it.
- R9: Writing to address 9 clears each flag whose data bit is 1. When a flag is set and cleared in the same cycle, the set wins.
- R10: Address 10 holds a 5-bit mask that reads back as written. `irq_o` is high exactly when some flag is set and its mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe. A read of the receive word removes bytes from the queue. |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, driven combinationally from `reg_addr_i` |
| tx_pop_i | input | 1 | Engine takes the oldest transmit byte |
| tx_byte_o | output | 8 | Oldest transmit byte |
| tx_valid_o | output | 1 | Transmit queue is not empty |
| rx_push_i | input | 1 | Engine delivers a received byte |
| rx_byte_i | input | 8 | Received byte |
| busy_i | input | 1 | Engine is mid-transfer |
| done_i | input | 1 | Pulse marking the end of a whole transfer |
| irq_o | output | 1 | Masked event request |

## Verification
The assertions check on every cycle that the following hold:
- An overfilled or drained-empty access on either side is followed by the matching error flag.
- A done pulse always leaves its flag set, and that flag stays set until a clear write targets it.
- An all-zero mask keeps `irq_o` low.
- No queue shows full and empty together.

Other behaviours only the directed scenarios can show:
- The byte order inside a word.
- The aliasing of the four data addresses.
- The zero padding of a partial receive word.
- That a dropped write leaves the queue contents unchanged.
- That a set beats a clear arriving in the same cycle.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int ADDR_W = 4;

  // address decode: upper two bits select the data windows
  localparam logic [1:0] SEL_TX = 2'b00;
  localparam logic [1:0] SEL_RX = 2'b01;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'd8;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 4'd9;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 4'd10;

  // status word bit positions
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_TX_FULL  = 3;
  localparam int ST_RX_EMPTY = 4;
  localparam int ST_RX_FULL  = 5;
  localparam int ST_BUSY     = 6;

  // event flag bit positions
  localparam int FLG_TX_EMPTY = 0;
  localparam int FLG_RX_FULL  = 1;
  localparam int FLG_DONE     = 2;
  localparam int FLG_TX_ERR   = 3;
  localparam int FLG_RX_ERR   = 4;
  localparam int NUM_FLAGS    = 5;
endpackage

// File: rtl/sff_byte_fifo.sv
// Byte queue with multi-lane push and pop; DEPTH must be a power of two.
module sff_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int LANES = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [$clog2(LANES+1)-1:0]   push_n_i,
  input  logic [LANES*8-1:0]           push_data_i,
  input  logic [$clog2(LANES+1)-1:0]   pop_n_i,
  output logic [LANES*8-1:0]           peek_o,
  output logic [$clog2(DEPTH):0]       count_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam int NW = $clog2(LANES + 1);

  logic [7:0]    mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (NW'(l) < push_n_i) mem_q[wr_q + PW'(l)] <= push_data_i[l*8 +: 8];
      end
      wr_q  <= wr_q + PW'(push_n_i);
      rd_q  <= rd_q + PW'(pop_n_i);
      cnt_q <= cnt_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_peek
    assign peek_o[l*8 +: 8] = mem_q[rd_q + PW'(l)];
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/sff_irq_ctrl.sv
// Sticky event flags, write-1-to-clear, set has priority, masked request.
module sff_irq_ctrl #(
  parameter int NF = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic          clr_wr_i,
  input  logic [NF-1:0] clr_data_i,
  input  logic          mask_wr_i,
  input  logic [NF-1:0] mask_data_i,
  output logic [NF-1:0] flags_o,
  output logic [NF-1:0] mask_o,
  output logic          irq_o
);
  logic [NF-1:0] flags_q, mask_q, clr_m;

  assign clr_m = clr_wr_i ? clr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_m) | set_i;
      if (mask_wr_i) mask_q <= mask_data_i;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & mask_q);
endmodule

// File: rtl/spi_fifo_regs.sv
module spi_fifo_regs
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              tx_pop_i,
  output logic [7:0]        tx_byte_o,
  output logic              tx_valid_o,
  input  logic              rx_push_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              irq_o
);
  localparam int LANES = DATA_W / 8;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int NW    = $clog2(LANES + 1);

  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic [DATA_W-1:0] tx_peek, rx_peek, rx_word, rx_push_word, status_w;
  logic [NW-1:0]     tx_push_n, tx_pop_n, rx_push_n, rx_pop_n, rx_avail;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic tx_wr, tx_room, rx_rd, tx_empty_d, rx_full_d;
  logic [NUM_FLAGS-1:0] flag_set, irq_flags, irq_mask;
  logic unused_bits;

  // ---------------- transmit side ----------------
  assign tx_empty  = (tx_cnt == '0);
  assign tx_full   = (tx_cnt == CW'(DEPTH));
  assign tx_wr     = reg_wr_i && (reg_addr_i[ADDR_W-1:ADDR_W-2] == SEL_TX);
  assign tx_room   = (CW'(DEPTH) - tx_cnt) >= CW'(LANES);
  assign tx_push_n = (tx_wr && tx_room) ? NW'(LANES) : '0;
  assign tx_pop_n  = NW'(tx_pop_i && !tx_empty);

  sff_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_tx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_n_i    (tx_push_n),
    .push_data_i (reg_wdata_i),
    .pop_n_i     (tx_pop_n),
    .peek_o      (tx_peek),
    .count_o     (tx_cnt)
  );

  assign tx_byte_o  = tx_peek[7:0];
  assign tx_valid_o = !tx_empty;

  // ---------------- receive side ----------------
  assign rx_empty     = (rx_cnt == '0);
  assign rx_full      = (rx_cnt == CW'(DEPTH));
  assign rx_rd        = reg_rd_i && (reg_addr_i[ADDR_W-1:ADDR_W-2] == SEL_RX);
  assign rx_avail     = (rx_cnt >= CW'(LANES)) ? NW'(LANES) : NW'(rx_cnt);
  assign rx_pop_n     = rx_rd ? rx_avail : '0;
  assign rx_push_n    = NW'(rx_push_i && !rx_full);
  assign rx_push_word = {{(DATA_W-8){1'b0}}, rx_byte_i};

  sff_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES)) u_rx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_n_i    (rx_push_n),
    .push_data_i (rx_push_word),
    .pop_n_i     (rx_pop_n),
    .peek_o      (rx_peek),
    .count_o     (rx_cnt)
  );

  // lanes past the stored count read as zero
  for (genvar l = 0; l < LANES; l++) begin : g_rx_lane
    assign rx_word[l*8 +: 8] = (CW'(l) < rx_cnt) ? rx_peek[l*8 +: 8] : 8'h00;
  end

  // ---------------- events ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_empty_d <= 1'b1;
      rx_full_d  <= 1'b0;
    end else begin
      tx_empty_d <= tx_empty;
      rx_full_d  <= rx_full;
    end
  end

  always_comb begin
    flag_set               = '0;
    flag_set[FLG_TX_EMPTY] = tx_empty && !tx_empty_d;
    flag_set[FLG_RX_FULL]  = rx_full && !rx_full_d;
    flag_set[FLG_DONE]     = done_i;
    flag_set[FLG_TX_ERR]   = (tx_wr && !tx_room) || (tx_pop_i && tx_empty);
    flag_set[FLG_RX_ERR]   = (rx_push_i && rx_full) || (rx_rd && rx_empty);
  end

  sff_irq_ctrl #(.NF(NUM_FLAGS)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (flag_set),
    .clr_wr_i    (reg_wr_i && (reg_addr_i == ADDR_FLAGS)),
    .clr_data_i  (reg_wdata_i[NUM_FLAGS-1:0]),
    .mask_wr_i   (reg_wr_i && (reg_addr_i == ADDR_MASK)),
    .mask_data_i (reg_wdata_i[NUM_FLAGS-1:0]),
    .flags_o     (irq_flags),
    .mask_o      (irq_mask),
    .irq_o       (irq_o)
  );

  // ---------------- read mux ----------------
  always_comb begin
    status_w              = '0;
    status_w[ST_TX_EMPTY] = tx_empty;
    status_w[ST_TX_FULL]  = tx_full;
    status_w[ST_RX_EMPTY] = rx_empty;
    status_w[ST_RX_FULL]  = rx_full;
    status_w[ST_BUSY]     = busy_i;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i[ADDR_W-1:ADDR_W-2] == SEL_RX) begin
      reg_rdata_o = rx_word;
    end else begin
      case (reg_addr_i)
        ADDR_STATUS: reg_rdata_o = status_w;
        ADDR_FLAGS:  reg_rdata_o = DATA_W'(irq_flags);
        ADDR_MASK:   reg_rdata_o = DATA_W'(irq_mask);
        default:     reg_rdata_o = '0;
      endcase
    end
  end

  assign unused_bits = ^{reg_wdata_i[DATA_W-1:NUM_FLAGS], tx_peek[DATA_W-1:8]};
endmodule

// File: rtl/sff_checker.sv
module sff_checker
  import spi_fifo_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 reg_wr_i,
  input logic [ADDR_W-1:0]    reg_addr_i,
  input logic [31:0]          reg_wdata_i,
  input logic                 tx_pop_i,
  input logic                 rx_push_i,
  input logic                 done_i,
  input logic                 irq_o,
  input logic                 tx_empty,
  input logic                 tx_full,
  input logic                 rx_empty,
  input logic                 rx_full,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] mask
);
  p_full_empty_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_full && tx_empty) && !(rx_full && rx_empty));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full && reg_wr_i && reg_addr_i[3:2] == SEL_TX) |=> flags[FLG_TX_ERR]);

  p_empty_pop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty && tx_pop_i) |=> flags[FLG_TX_ERR]);

  p_rx_overrun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full && rx_push_i) |=> flags[FLG_RX_ERR]);

  p_done_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> flags[FLG_DONE]);

  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags[FLG_DONE] && !(reg_wr_i && reg_addr_i == ADDR_FLAGS && reg_wdata_i[FLG_DONE]))
      |=> flags[FLG_DONE]);

  p_mask_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);
endmodule

bind spi_fifo_regs sff_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .tx_pop_i    (tx_pop_i),
  .rx_push_i   (rx_push_i),
  .done_i      (done_i),
  .irq_o       (irq_o),
  .tx_empty    (tx_empty),
  .tx_full     (tx_full),
  .rx_empty    (rx_empty),
  .rx_full     (rx_full),
  .flags       (irq_flags),
  .mask        (irq_mask)
);

// File: tb/sim_spi_fifo_regs.sv
module sim_spi_fifo_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0, tx_pop = 0, rx_push = 0, busy = 0, done = 0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0]  tx_byte, rx_byte = '0;
  logic        tx_valid, irq;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_pop_i(tx_pop), .tx_byte_o(tx_byte), .tx_valid_o(tx_valid),
    .rx_push_i(rx_push), .rx_byte_i(rx_byte), .busy_i(busy), .done_i(done),
    .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic eng_pop(output logic [7:0] b, output logic v);
    @(negedge clk); #1 b = tx_byte; v = tx_valid; tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_push = 1'b1;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd8, d);  check("R1 status after reset", d, 32'h14);
    rd(4'd9, d);  check("R1 flags after reset", d, 32'h0);
    rd(4'd10, d); check("R1 mask after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
  endtask

  task automatic t_tx_order();
    logic [7:0] b; logic v; logic [31:0] d;
    wr(4'd9, 32'h1F);
    wr(4'd0, 32'h44332211);
    wr(4'd3, 32'h88776655);
    for (int i = 0; i < 8; i++) begin
      eng_pop(b, v);
      check("R2 tx byte order", {23'b0, v, b}, {23'b0, 1'b1, 8'(8'h11 * (i + 1))});
    end
    rd(4'd8, d); check("R7 tx empty after drain", d & 32'h0C, 32'h04);
    rd(4'd9, d); check("R8 tx empty event", d & 32'h1, 32'h1);
  endtask

  task automatic t_tx_overflow();
    logic [7:0] b; logic v; logic [31:0] d;
    wr(4'd9, 32'h1F);
    for (int k = 0; k < 4; k++)
      wr(4'(k), {8'(4*k+3), 8'(4*k+2), 8'(4*k+1), 8'(4*k)});
    rd(4'd8, d); check("R7 tx full bit", d & 32'h0C, 32'h08);
    rd(4'd9, d); check("R3 no error before overflow", d & 32'h8, 32'h0);
    wr(4'd1, 32'hDEADBEEF);
    rd(4'd9, d); check("R3 overflow sets tx error", d & 32'h8, 32'h8);
    for (int i = 0; i < 16; i++) begin
      eng_pop(b, v);
      check("R3 contents kept after dropped write", {23'b0, v, b}, {23'b0, 1'b1, 8'(i)});
    end
    check("R3 queue empty after 16 pops", {31'b0, tx_valid}, 32'h0);
    wr(4'd9, 32'h1F);
    eng_pop(b, v);
    check("R4 pop of empty reports invalid", {31'b0, v}, 32'h0);
    rd(4'd9, d); check("R4 empty pop sets tx error", d & 32'h8, 32'h8);
    rd(4'd8, d); check("R4 queue still empty", d & 32'h04, 32'h04);
  endtask

  task automatic t_rx_partial();
    logic [31:0] d;
    wr(4'd9, 32'h1F);
    for (int i = 0; i < 6; i++) eng_push(8'(8'hA0 + i));
    rd(4'd4, d); check("R5 rx word order", d, 32'hA3A2A1A0);
    rd(4'd7, d); check("R5 partial rx word zero padded", d, 32'h0000A5A4);
    rd(4'd8, d); check("R7 rx empty bit", d & 32'h30, 32'h10);
    rd(4'd9, d); check("R6 no rx error yet", d & 32'h10, 32'h0);
    rd(4'd5, d); check("R6 empty read returns zero", d, 32'h0);
    rd(4'd9, d); check("R6 empty read sets rx error", d & 32'h10, 32'h10);
  endtask

  task automatic t_rx_full();
    logic [31:0] d;
    wr(4'd9, 32'h1F);
    for (int i = 0; i < 16; i++) eng_push(8'(8'h40 + i));
    rd(4'd8, d); check("R7 rx full bit", d & 32'h30, 32'h20);
    rd(4'd9, d); check("R8 rx full event", d & 32'h12, 32'h02);
    eng_push(8'hFF);
    rd(4'd9, d); check("R6 overrun sets rx error", d & 32'h10, 32'h10);
    for (int k = 0; k < 4; k++) begin
      rd(4'(4 + k), d);
      check("R6 overrun byte dropped", d,
            {8'(8'h40+4*k+3), 8'(8'h40+4*k+2), 8'(8'h40+4*k+1), 8'(8'h40+4*k)});
    end
    rd(4'd8, d); check("R6 rx empty after drain", d & 32'h30, 32'h10);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(4'd9, 32'h1F);
    rd(4'd9, d); check("R9 clear all flags", d, 32'h0);
    wr(4'd10, 32'h04);
    rd(4'd10, d); check("R10 mask readback", d, 32'h04);
    check("R10 irq low with no flag", {31'b0, irq}, 32'h0);
    @(negedge clk); done = 1'b1; @(negedge clk); done = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd9, d); check("R8 done flag sticky", d & 32'h4, 32'h4);
    check("R10 irq on masked flag", {31'b0, irq}, 32'h1);
    wr(4'd10, 32'h00);
    check("R10 irq low when masked off", {31'b0, irq}, 32'h0);
    wr(4'd10, 32'h04);
    @(negedge clk); done = 1'b1; reg_addr = 4'd9; reg_wdata = 32'h4; reg_wr = 1'b1;
    @(negedge clk); done = 1'b0; reg_wr = 1'b0;
    rd(4'd9, d); check("R9 set wins over clear", d & 32'h4, 32'h4);
    wr(4'd9, 32'h4);
    rd(4'd9, d); check("R9 write one clears", d & 32'h4, 32'h0);
    check("R10 irq drops after clear", {31'b0, irq}, 32'h0);
    busy = 1'b1;
    rd(4'd8, d); check("R7 busy bit", d, 32'h54);
    busy = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_order();
    t_tx_overflow();
    t_rx_partial();
    t_rx_full();
    t_irq();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule